// File: doc/BRIEF.md
# Dual Reloading Down-Counter Timer

This block holds two independent down-counters, each with its own reload value. Each counter takes its count ticks from one of two sources, chosen separately for each counter: a one-cycle tick from an external prescaler, or rising edges seen on an asynchronous event input. When a counter is at zero and gets a tick, it loads its reload value on that tick. It does not wrap.

Counter 1 can invert a square-wave output each time it underflows. Software sets the starting level of that output. Counter 1's pending flag is set only when the output goes from low to high. Counter 2's pending flag is set on every underflow. Each flag has an interrupt enable, and each interrupt output is a registered AND of the flag and its enable.

All state is reached through a synchronous write port and a read port. The read data is registered and is due one cycle after the address is presented.

Top module: `dual_reload_timer`

## Requirements
- R1: Synchronous reset clears both counters, both reload values, all control fields, the wave output, both pending flags, both interrupt outputs and the read data.
- R2: A counter decrements by one on each tick of its selected source. Select code 1 is the prescaler tick and code 2 is the event edge. Codes 0 and 3 stop the counter. The select fields sit at control bits [1:0] for counter 1 and [3:2] for counter 2.
- R3: A tick that arrives while a counter holds zero loads that counter's reload value, which is the value held before any write in the same cycle.
- R4: The event input passes through two synchronizer flops. Each low-to-high transition gives exactly one tick, and the counter changes on the third rising clock edge after the input rises. A level held high gives no further ticks.
- R5: When the toggle enable (control bit 4) is set, every underflow of counter 1 inverts the wave output. When it is clear, the output holds.
- R6: Writing address 5 sets the wave output to wdata[0]. This write wins over a toggle in the same cycle and never sets a pending flag.
- R7: Counter 1's pending flag (status bit 0) is set only when a toggle takes the wave output from low to high.
- R8: Every underflow of counter 2 sets its pending flag (status bit 1).
- R9: Writing 1 to a status bit at address 6 clears that flag. A set event in the same cycle wins, and the flag stays set.
- R10: Each interrupt output equals its pending flag ANDed with its enable (control bit 5 for counter 1, bit 6 for counter 2), one cycle later.
- R11: Writing address 2 or 3 loads counter 1 or 2 directly. The write wins over a tick in the same cycle, and that tick causes no underflow.
- R12: The read map is: 0/1 reload values, 2/3 counters, 4 control, 5 wave level in bit 0, 6 pending flags, 7 reads zero. rdata is registered one cycle after addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_tick | input | 1 | Prescaled system tick, one cycle wide |
| evt_in | input | 1 | Asynchronous external event input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| wave_out | output | 1 | Square-wave output driven by counter 1 |
| irq1 | output | 1 | Counter 1 interrupt |
| irq2 | output | 1 | Counter 2 interrupt |

## Verification
A prescaler tick or a write changes counter, wave and pending state at the same edge that samples it. The interrupt pins follow one edge later. A read shows state one edge after the address is presented. An event-input edge reaches the counter only on the third edge.

The bench drives inputs on the falling edge and advances a cycle model of these latencies by exactly one edge per step. It compares every output on the next falling edge, so each result is checked in the cycle it is due and in no other.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_EVT  = 2'd2,
    SRC_OFF3 = 2'd3
  } src_sel_e;

  localparam logic [2:0] A_RLD1  = 3'd0;
  localparam logic [2:0] A_RLD2  = 3'd1;
  localparam logic [2:0] A_CNT1  = 3'd2;
  localparam logic [2:0] A_CNT2  = 3'd3;
  localparam logic [2:0] A_CTRL  = 3'd4;
  localparam logic [2:0] A_LEVEL = 3'd5;
  localparam logic [2:0] A_STAT  = 3'd6;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic evt_in,
  output logic evt_edge
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk)
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= evt_in;
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk)
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];

  assign evt_edge = chain[STAGES-1] & ~prev;

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    evt_edge |=> !evt_edge); // R4
endmodule

// File: rtl/tick_mux.sv
module tick_mux
  import dual_timer_pkg::*;
(
  input  src_sel_e sel,
  input  logic     sys_tick,
  input  logic     evt_edge,
  output logic     tick
);
  always_comb begin
    unique case (sel)
      SRC_SYS: tick = sys_tick;
      SRC_EVT: tick = evt_edge;
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/down_counter.sv
module down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         uf
);
  logic at_zero;
  assign at_zero = (cnt == '0);
  assign uf      = tick & at_zero & ~ld;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (uf)   cnt <= reload;
    else if (tick) cnt <= cnt - 1'b1;
  end

  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && at_zero && !ld) |=> cnt == $past(reload)); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tick && !at_zero && !ld) |=> cnt == $past(cnt) - 1'b1); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(cnt)); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld |=> cnt == $past(ld_val)); // R11
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import dual_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_tick,
  input  logic              evt_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              wave_out,
  output logic              irq1,
  output logic              irq2
);
  localparam int NCNT   = 2;
  localparam int CTRL_W = 7;

  logic             evt_edge;
  logic [CNT_W-1:0] reload [NCNT];
  logic [CNT_W-1:0] cnt    [NCNT];
  logic [NCNT-1:0]  tick, ld, uf, pend, ie;
  src_sel_e         sel    [NCNT];
  logic             tgl_en;
  logic             lvl_wr, rise1;

  evt_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .evt_in(evt_in), .evt_edge(evt_edge)
  );

  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      tick_mux u_mux (
        .sel(sel[i]), .sys_tick(sys_tick), .evt_edge(evt_edge), .tick(tick[i])
      );
      assign ld[i] = wr_en && (addr == A_CNT1 + ADDR_W'(i));
      down_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick[i]), .ld(ld[i]), .ld_val(wdata),
        .reload(reload[i]), .cnt(cnt[i]), .uf(uf[i])
      );
      always_ff @(posedge clk)
        if (rst) reload[i] <= '0;
        else if (wr_en && addr == A_RLD1 + ADDR_W'(i)) reload[i] <= wdata;
    end
  endgenerate

  // control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      sel[0] <= SRC_OFF;
      sel[1] <= SRC_OFF;
      tgl_en <= 1'b0;
      ie     <= '0;
    end else if (wr_en && addr == A_CTRL) begin
      sel[0] <= src_sel_e'(wdata[1:0]);
      sel[1] <= src_sel_e'(wdata[3:2]);
      tgl_en <= wdata[4];
      ie     <= wdata[6:5];
    end
  end

  // wave output: level write wins over toggle
  assign lvl_wr = wr_en && (addr == A_LEVEL);
  assign rise1  = uf[0] && tgl_en && !wave_out && !lvl_wr;

  always_ff @(posedge clk) begin
    if (rst)                  wave_out <= 1'b0;
    else if (lvl_wr)          wave_out <= wdata[0];
    else if (uf[0] && tgl_en) wave_out <= ~wave_out;
  end

  // pending flags: set wins over clear
  logic [NCNT-1:0] pset, pclr;
  assign pset = {uf[1], rise1};
  assign pclr = (wr_en && addr == A_STAT) ? wdata[NCNT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pset | (pend & ~pclr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq1 <= 1'b0;
      irq2 <= 1'b0;
    end else begin
      irq1 <= pend[0] & ie[0];
      irq2 <= pend[1] & ie[1];
    end
  end

  // registered read port
  logic [CTRL_W-1:0] ctrl_rd;
  assign ctrl_rd = {ie, tgl_en, sel[1], sel[0]};

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (addr)
        A_RLD1:  rdata <= reload[0];
        A_RLD2:  rdata <= reload[1];
        A_CNT1:  rdata <= cnt[0];
        A_CNT2:  rdata <= cnt[1];
        A_CTRL:  rdata <= CNT_W'(ctrl_rd);
        A_LEVEL: rdata <= CNT_W'(wave_out);
        A_STAT:  rdata <= CNT_W'(pend);
        default: rdata <= '0;
      endcase
    end
  end

  AST_IRQ1_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq1 == $past(pend[0] & ie[0])); // R10
  AST_IRQ2_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq2 == $past(pend[1] & ie[1])); // R10
  AST_UF2_SETS: assert property (@(posedge clk) disable iff (rst)
    uf[1] |=> pend[1]); // R8
  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(uf[0] && tgl_en) && !lvl_wr) |=> $stable(wave_out)); // R5
  AST_PEND1_ONLY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[0]) |-> $rose(wave_out)); // R7
endmodule

// File: tb/test_dual_reload_timer.sv
module test_dual_reload_timer;
  logic        clk = 1'b0;
  logic        rst;
  logic        sys_tick, evt_in, wr_en;
  logic [2:0]  addr;
  logic [15:0] wdata, rdata;
  logic        wave_out, irq1, irq2;
  int          errors = 0, checks = 0;

  always #10 clk = ~clk;

  dual_reload_timer i_dual_reload_timer (
    .clk(clk), .rst(rst), .sys_tick(sys_tick), .evt_in(evt_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wave_out(wave_out),
    .irq1(irq1), .irq2(irq2)
  );

  // cycle model built from the requirements
  logic [15:0] m_rl [2];
  logic [15:0] m_cnt[2];
  logic [1:0]  m_sel[2];
  logic        m_tgl, m_wave;
  logic [1:0]  m_ie, m_pend, m_irq;
  logic [15:0] m_rd;
  logic        m_s1, m_s2, m_pv;

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_rl[i] = 0; m_cnt[i] = 0; m_sel[i] = 0;
    end
    m_tgl = 0; m_wave = 0; m_ie = 0; m_pend = 0; m_irq = 0; m_rd = 0;
    m_s1 = 0; m_s2 = 0; m_pv = 0;
  endtask

  function automatic logic [15:0] read_mux(input logic [2:0] a);
    case (a)
      3'd0: return m_rl[0];
      3'd1: return m_rl[1];
      3'd2: return m_cnt[0];
      3'd3: return m_cnt[1];
      3'd4: return {9'd0, m_ie, m_tgl, m_sel[1], m_sel[0]};
      3'd5: return {15'd0, m_wave};
      3'd6: return {14'd0, m_pend};
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance one clock with the inputs currently driven, then compare
  task automatic step();
    logic [15:0] n_cnt[2];
    logic [1:0]  uf, pset, pclr;
    logic        edg, t, ld, lw, n_wave;
    edg = m_s2 & ~m_pv;
    lw  = wr_en && addr == 3'd5;
    for (int i = 0; i < 2; i++) begin
      t  = (m_sel[i] == 2'd1) ? sys_tick : (m_sel[i] == 2'd2) ? edg : 1'b0;
      ld = wr_en && addr == 3'(2 + i);
      uf[i] = t && m_cnt[i] == 0 && !ld;
      n_cnt[i] = ld ? wdata : uf[i] ? m_rl[i] : t ? m_cnt[i] - 1 : m_cnt[i];
    end
    n_wave = lw ? wdata[0] : (uf[0] && m_tgl) ? ~m_wave : m_wave;
    pset = {uf[1], uf[0] && m_tgl && !m_wave && !lw};
    pclr = (wr_en && addr == 3'd6) ? wdata[1:0] : 2'b00;
    m_rd  = read_mux(addr);
    m_irq = m_pend & m_ie;
    m_pend = pset | (m_pend & ~pclr);
    m_wave = n_wave;
    for (int i = 0; i < 2; i++) begin
      if (wr_en && addr == 3'(i)) m_rl[i] = wdata;
      m_cnt[i] = n_cnt[i];
    end
    if (wr_en && addr == 3'd4) begin
      m_sel[0] = wdata[1:0]; m_sel[1] = wdata[3:2];
      m_tgl = wdata[4]; m_ie = wdata[6:5];
    end
    m_pv = m_s2; m_s2 = m_s1; m_s1 = evt_in;
    @(posedge clk);
    @(negedge clk);
    chk(wave_out === m_wave, "R5 wave_out", 16'(wave_out), 16'(m_wave));
    chk(irq1 === m_irq[0], "R10 irq1", 16'(irq1), 16'(m_irq[0]));
    chk(irq2 === m_irq[1], "R10 irq2", 16'(irq2), 16'(m_irq[1]));
    chk(rdata === m_rd, "R12 rdata", rdata, m_rd);
  endtask

  task automatic idle();
    wr_en = 0; sys_tick = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d; step(); wr_en = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] mask,
                        input logic [15:0] exp, input string tag);
    idle(); addr = a; step();
    chk((rdata & mask) === exp, tag, rdata & mask, exp);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      sys_tick = 1; step(); sys_tick = 0;
    end
  endtask

  logic        done = 0;
  logic [15:0] held;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst = 1; sys_tick = 0; evt_in = 0; wr_en = 0; addr = 0; wdata = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk(wave_out === 0 && irq1 === 0 && irq2 === 0 && rdata === 0,
        "R1 outputs after reset", {wave_out, irq1, irq2, rdata[12:0]}, 16'd0);
    rd_chk(3'd2, 16'hffff, 16'd0, "R1 counter1 after reset");
    rd_chk(3'd6, 16'hffff, 16'd0, "R1 pending after reset");

    // counter 1 on sys tick, toggle and irq enabled
    wr(3'd0, 16'd3);
    wr(3'd4, 16'h0031);
    tick(1);
    chk(wave_out === 1, "R5 toggle on underflow", 16'(wave_out), 16'd1);
    rd_chk(3'd2, 16'hffff, 16'd3, "R3 reload on zero tick");
    chk(irq1 === 1, "R10 irq1 raised", 16'(irq1), 16'd1);
    rd_chk(3'd6, 16'h0001, 16'd1, "R7 pend1 on rising toggle");
    tick(1);
    rd_chk(3'd2, 16'hffff, 16'd2, "R2 decrement by one");
    wr(3'd6, 16'd1);
    rd_chk(3'd6, 16'h0001, 16'd0, "R9 clear pend1");
    tick(3);
    chk(wave_out === 0, "R5 toggle back low", 16'(wave_out), 16'd0);
    rd_chk(3'd6, 16'h0001, 16'd0, "R7 falling toggle leaves pend1 clear");
    wr(3'd5, 16'd1);
    chk(wave_out === 1, "R6 level write", 16'(wave_out), 16'd1);
    rd_chk(3'd6, 16'h0001, 16'd0, "R6 level write sets no pending");

    // counter 2 on event edges
    wr(3'd1, 16'd1);
    wr(3'd4, 16'h0079);
    evt_in = 1;
    repeat (2) step();
    rd_chk(3'd3, 16'hffff, 16'd0, "R4 no tick before third edge");
    rd_chk(3'd3, 16'hffff, 16'd1, "R4 one tick per rising edge");
    rd_chk(3'd6, 16'h0002, 16'd2, "R8 pend2 on underflow");
    repeat (4) step();
    rd_chk(3'd3, 16'hffff, 16'd1, "R4 held level adds no ticks");
    evt_in = 0;
    repeat (3) step();

    // set beats clear on counter 2
    wr(3'd4, 16'h0075);
    wr(3'd6, 16'd2);
    wr(3'd3, 16'd0);
    wr_en = 1; addr = 3'd6; wdata = 16'd2; sys_tick = 1; step(); idle();
    rd_chk(3'd6, 16'h0002, 16'd2, "R9 set wins over clear");
    chk(irq2 === 1, "R10 irq2 raised", 16'(irq2), 16'd1);

    // write beats tick
    wr_en = 1; addr = 3'd3; wdata = 16'd5; sys_tick = 1; step(); idle();
    rd_chk(3'd3, 16'hffff, 16'd5, "R11 write wins over tick");
    wr_en = 1; addr = 3'd3; wdata = 16'd0; sys_tick = 1; step(); idle();
    rd_chk(3'd6, 16'h0002, 16'd2, "R11 loaded zero with tick gives no reload");
    rd_chk(3'd3, 16'hffff, 16'd0, "R11 counter holds written zero");

    // stopped counters
    wr(3'd4, 16'h000f);
    idle(); addr = 3'd2; step();
    held = rdata;
    tick(4);
    rd_chk(3'd2, 16'hffff, held, "R2 select code 3 stops counter");
    rd_chk(3'd4, 16'hffff, 16'h000f, "R12 control readback");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      sys_tick = ($urandom % 3) == 0;
      if (($urandom % 5) == 0) evt_in = ~evt_in;
      addr  = 3'($urandom);
      wr_en = ($urandom % 6) == 0;
      if (addr <= 3'd3) wdata = 16'($urandom % 6);
      else if (addr == 3'd4) wdata = 16'($urandom) & 16'h007f;
      else wdata = 16'($urandom);
      if (wr_en && addr == 3'd4 && (wdata[1:0] == 0)) wdata[1:0] = 2'd1;
      step();
    end
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule